// File: doc/BRIEF.md
# Serial Port Error Flag Unit

This block keeps the three error flags of a serial port that runs either as an asynchronous UART or as a synchronous shift interface. The synchronous interface can take its transfer clock from outside (clock-input mode) or drive the clock itself (clock-output mode). The receiver and transmitter datapaths send single-cycle event strobes to the block, along with level signals that describe how full the buffers and FIFOs are. From these the block decides which flags to raise.

Software sees the flags as three bits of a status/control register word. A read of that word returns the current flags in the same cycle and clears them on the next clock edge. If a new error event arrives in the cycle of a read, the event takes priority. One flag bit has two meanings: it reports a parity mismatch in UART mode and a transmit underrun in clock-input synchronous mode.

Top module: `serr_flags`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, every bit of `ctrl_rdata` is 0.
- R2: `mode` 2'b00 is UART, 2'b01 is synchronous with clock input, and 2'b10 and 2'b11 are synchronous with clock output. In UART or clock-input mode with `rx_fifo_en`=0, a `rx_done` strobe while `rx_buf_full`=1 sets the overrun flag (`ctrl_rdata[4]`) on the next clock edge. A `rx_done` strobe while `rx_buf_full`=0 leaves the flag unchanged.
- R3: With `rx_fifo_en`=1, a `rx_done` strobe sets the overrun flag only when `rx_fifo_level` >= `rx_fifo_limit`. Below that level the flag does not change.
- R4: In UART mode, a `par_bad` strobe sets `ctrl_rdata[3]` on the next edge. In the synchronous modes `par_bad` has no effect.
- R5: In clock-input mode with `dbuf_en`=1, `ctrl_rdata[3]` (underrun) sets on the next edge when all of these hold at once: `xfer_clk` strobes, `tx_shift_idle`=1, `tx_buf_full`=0, and either `tx_fifo_en`=0 or `tx_fifo_level`=0. In UART mode the transmit-side inputs do not affect `ctrl_rdata[3]`.
- R6: In clock-input mode with `dbuf_en`=0, `ctrl_rdata[3]` is 0 one edge later and stays 0.
- R7: In clock-output mode, all three flags are 0 one edge later and stay 0, whatever the inputs do.
- R8: In UART mode, a `stop_valid` strobe with `stop_bit`=0 sets the framing flag (`ctrl_rdata[2]`) on the next edge. A `stop_valid` strobe with `stop_bit`=1 does not set it. In both synchronous modes the framing flag is 0.
- R9: When `rd_en` is high, `ctrl_rdata` shows the flags as they were before the read. Every flag whose set condition is absent in that cycle is 0 after the next edge.
- R10: When a flag's set condition and `rd_en` fall in the same cycle, that flag is 1 after the edge.
- R11: Bits 7:5 and 1:0 of `ctrl_rdata` always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | 00 UART, 01 sync clock-in, 1x sync clock-out |
| dbuf_en | input | 1 | Transmit double buffer enabled |
| rx_fifo_en | input | 1 | Receive FIFO enabled |
| tx_fifo_en | input | 1 | Transmit FIFO enabled |
| rx_fifo_level | input | LW | Receive FIFO entries in use |
| rx_fifo_limit | input | LW | Usable receive FIFO depth |
| tx_fifo_level | input | LW | Transmit FIFO entries in use |
| rx_buf_full | input | 1 | Receive holding buffer not yet read |
| tx_buf_full | input | 1 | Transmit double buffer holds data |
| tx_shift_idle | input | 1 | Transmit shifter has finished its word |
| rx_done | input | 1 | Strobe: a received frame completed |
| par_bad | input | 1 | Strobe: received parity mismatched |
| stop_valid | input | 1 | Strobe: stop bit sampled |
| stop_bit | input | 1 | Sampled stop bit value |
| xfer_clk | input | 1 | Strobe: transfer clock edge |
| rd_en | input | 1 | Register read, clears flags |
| ctrl_rdata | output | REG_W | Register word with flags at bits 4, 3, 2 |

## Verification
Every flag result appears after exactly one rising edge following the strobe that causes it. The read value is combinational and belongs to the cycle in which `rd_en` is high. The bench applies inputs on the falling edge and computes the expected next flag state from the inputs and the previous expected state. It compares that state with `ctrl_rdata` on the following falling edge, one register stage later. The directed cases place set and clear strobes in the same cycle and put FIFO levels exactly at and just below the limit.

// File: rtl/serr_flags.sv
module serr_flags #(
  parameter int FIFO_DEPTH = 16,
  parameter int REG_W      = 8,
  localparam int LW        = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             dbuf_en,
  input  logic             rx_fifo_en,
  input  logic             tx_fifo_en,
  input  logic [LW-1:0]    rx_fifo_level,
  input  logic [LW-1:0]    rx_fifo_limit,
  input  logic [LW-1:0]    tx_fifo_level,
  input  logic             rx_buf_full,
  input  logic             tx_buf_full,
  input  logic             tx_shift_idle,
  input  logic             rx_done,
  input  logic             par_bad,
  input  logic             stop_valid,
  input  logic             stop_bit,
  input  logic             xfer_clk,
  input  logic             rd_en,
  output logic [REG_W-1:0] ctrl_rdata
);
  localparam int OVR_BIT = 4;
  localparam int PAR_BIT = 3;
  localparam int FRM_BIT = 2;
  localparam logic [1:0] M_UART = 2'b00;
  localparam logic [1:0] M_SIN  = 2'b01;

  logic ovr_q, par_q, frm_q;

  wire is_uart  = (mode == M_UART);
  wire is_sin   = (mode == M_SIN);
  wire rx_live  = is_uart | is_sin;
  wire par_live = is_uart | (is_sin & dbuf_en);

  wire no_room  = rx_fifo_en ? (rx_fifo_level >= rx_fifo_limit) : rx_buf_full;
  wire tx_dry   = !tx_buf_full && (!tx_fifo_en || tx_fifo_level == '0);

  wire ovr_set  = rx_live & rx_done & no_room;
  wire udr_set  = is_sin & dbuf_en & xfer_clk & tx_shift_idle & tx_dry;
  wire par_set  = is_uart ? par_bad : udr_set;
  wire frm_set  = is_uart & stop_valid & ~stop_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
      par_q <= 1'b0;
      frm_q <= 1'b0;
    end else begin
      ovr_q <= rx_live  & (ovr_set | (ovr_q & ~rd_en));
      par_q <= par_live & (par_set | (par_q & ~rd_en));
      frm_q <= is_uart  & (frm_set | (frm_q & ~rd_en));
    end
  end

  always_comb begin
    ctrl_rdata          = '0;
    ctrl_rdata[OVR_BIT] = ovr_q;
    ctrl_rdata[PAR_BIT] = par_q;
    ctrl_rdata[FRM_BIT] = frm_q;
  end
endmodule

module serr_flags_chk #(
  parameter int REG_W = 8,
  parameter int LW    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode,
  input logic             dbuf_en,
  input logic             rx_fifo_en,
  input logic [LW-1:0]    rx_fifo_level,
  input logic [LW-1:0]    rx_fifo_limit,
  input logic             rx_buf_full,
  input logic             rx_done,
  input logic             par_bad,
  input logic             stop_valid,
  input logic             stop_bit,
  input logic             xfer_clk,
  input logic             rd_en,
  input logic [REG_W-1:0] ctrl_rdata
);
  AST_OVR_NOFIFO: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode[1] && rx_done && rx_buf_full && !rx_fifo_en) |=> ctrl_rdata[4]); // R2
  AST_OVR_FIFO: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode[1] && rx_done && rx_fifo_en && rx_fifo_level >= rx_fifo_limit) |=> ctrl_rdata[4]); // R3
  AST_PAR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && par_bad) |=> ctrl_rdata[3]); // R4
  AST_UDR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && !dbuf_en) |=> !ctrl_rdata[3]); // R6
  AST_CLKOUT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    mode[1] |=> (ctrl_rdata[4:2] == 3'b000)); // R7
  AST_FRM_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && stop_valid && !stop_bit) |=> ctrl_rdata[2]); // R8
  AST_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rx_done && !par_bad && !stop_valid && !xfer_clk) |=> (ctrl_rdata[4:2] == 3'b000)); // R9
  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rdata[REG_W-1:5] == '0) && (ctrl_rdata[1:0] == 2'b00)); // R11
endmodule

bind serr_flags serr_flags_chk #(.REG_W(REG_W), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .dbuf_en(dbuf_en), .rx_fifo_en(rx_fifo_en),
  .rx_fifo_level(rx_fifo_level), .rx_fifo_limit(rx_fifo_limit), .rx_buf_full(rx_buf_full),
  .rx_done(rx_done), .par_bad(par_bad), .stop_valid(stop_valid), .stop_bit(stop_bit),
  .xfer_clk(xfer_clk), .rd_en(rd_en), .ctrl_rdata(ctrl_rdata));

// File: tb/test_serr_flags.sv
module test_serr_flags;
  localparam int LW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic dbuf_en = 1'b0, rx_fifo_en = 1'b0, tx_fifo_en = 1'b0;
  logic [LW-1:0] rx_fifo_level = '0, rx_fifo_limit = '0, tx_fifo_level = '0;
  logic rx_buf_full = 1'b0, tx_buf_full = 1'b0, tx_shift_idle = 1'b0;
  logic rx_done = 1'b0, par_bad = 1'b0, stop_valid = 1'b0, stop_bit = 1'b1;
  logic xfer_clk = 1'b0, rd_en = 1'b0;
  logic [7:0] ctrl_rdata;

  int checks = 0;
  int errors = 0;
  logic [2:0] cur = 3'b000;

  always #2.5 clk = ~clk;

  serr_flags i_serr_flags (
    .clk(clk), .rst_n(rst_n), .mode(mode), .dbuf_en(dbuf_en),
    .rx_fifo_en(rx_fifo_en), .tx_fifo_en(tx_fifo_en),
    .rx_fifo_level(rx_fifo_level), .rx_fifo_limit(rx_fifo_limit),
    .tx_fifo_level(tx_fifo_level), .rx_buf_full(rx_buf_full),
    .tx_buf_full(tx_buf_full), .tx_shift_idle(tx_shift_idle),
    .rx_done(rx_done), .par_bad(par_bad), .stop_valid(stop_valid),
    .stop_bit(stop_bit), .xfer_clk(xfer_clk), .rd_en(rd_en),
    .ctrl_rdata(ctrl_rdata));

  function automatic logic [7:0] pack(logic [2:0] f);
    return {3'b000, f, 2'b00};
  endfunction

  // flags order {overrun, parity/underrun, framing}
  function automatic logic [2:0] next_flags(logic [2:0] f);
    logic uart, sin, o, p, r, s_o, s_p, s_r;
    uart = (mode == 2'b00);
    sin  = (mode == 2'b01);
    s_o = (uart || sin) && rx_done &&
          (rx_fifo_en ? (rx_fifo_level >= rx_fifo_limit) : rx_buf_full);
    if (uart) s_p = par_bad;
    else s_p = sin && dbuf_en && xfer_clk && tx_shift_idle && !tx_buf_full &&
               (!tx_fifo_en || tx_fifo_level == 0);
    s_r = uart && stop_valid && !stop_bit;
    o = (uart || sin) && (s_o || (f[2] && !rd_en));
    p = (uart || (sin && dbuf_en)) && (s_p || (f[1] && !rd_en));
    r = uart && (s_r || (f[0] && !rd_en));
    return {o, p, r};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic quiet();
    rx_done = 0; par_bad = 0; stop_valid = 0; stop_bit = 1; xfer_clk = 0; rd_en = 0;
  endtask

  task automatic tick(string req);
    logic [2:0] exp;
    check({req, " read value"}, ctrl_rdata, pack(cur));
    exp = next_flags(cur);
    @(posedge clk);
    @(negedge clk);
    check(req, ctrl_rdata, pack(exp));
    cur = exp;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk);
    check("R1 in reset", ctrl_rdata, 8'h00);
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 after reset", ctrl_rdata, 8'h00);

    // R2 overrun without FIFO
    mode = 2'b00; rx_buf_full = 0; rx_done = 1; tick("R2 buffer empty");
    rx_buf_full = 1; tick("R2 buffer unread");
    quiet(); rd_en = 1; tick("R9 read clears");
    quiet(); tick("R9 stays clear");

    // R3 FIFO boundary
    rx_fifo_en = 1; rx_fifo_limit = 5'd8; rx_buf_full = 1;
    rx_fifo_level = 5'd7; rx_done = 1; tick("R3 below limit");
    rx_fifo_level = 5'd8; tick("R3 at limit");
    quiet(); rx_fifo_en = 0; rd_en = 1; tick("R9 clear");

    // R4 and R8
    quiet(); par_bad = 1; tick("R4 parity uart");
    quiet(); stop_valid = 1; stop_bit = 1; tick("R8 good stop");
    stop_bit = 0; tick("R8 bad stop");
    // R10 set wins
    quiet(); rd_en = 1; stop_valid = 1; stop_bit = 0; tick("R10 set beats clear");
    quiet(); rd_en = 1; tick("R9 clear all");

    // R5 underrun
    quiet(); mode = 2'b01; dbuf_en = 1; tx_shift_idle = 1; tx_buf_full = 0;
    tx_fifo_en = 1; tx_fifo_level = 5'd3; xfer_clk = 1; tick("R5 fifo refills");
    tx_fifo_level = 5'd0; tick("R5 underrun");
    quiet(); par_bad = 1; rd_en = 1; tick("R4 parity ignored in sync");
    quiet(); stop_valid = 1; stop_bit = 0; tick("R8 framing zero in sync");
    // R6
    quiet(); xfer_clk = 1; tick("R5 underrun again");
    quiet(); dbuf_en = 0; xfer_clk = 1; tick("R6 double buffer off");
    // R7
    quiet(); mode = 2'b00; par_bad = 1; stop_valid = 1; stop_bit = 0; rx_done = 1;
    rx_buf_full = 1; tick("R7 prepare");
    quiet(); mode = 2'b10; rx_done = 1; xfer_clk = 1; dbuf_en = 1; tick("R7 clock out zero");
    quiet(); mode = 2'b00; tx_shift_idle = 1; xfer_clk = 1; tick("R5 uart ignores tx");

    // random phases
    for (int ph = 0; ph < 16; ph++) begin
      mode = ph[1:0]; dbuf_en = ph[2]; rx_fifo_en = ph[3];
      for (int c = 0; c < 1500; c++) begin
        tx_fifo_en    = $urandom_range(0, 1);
        rx_fifo_limit = 5'($urandom_range(1, 16));
        rx_fifo_level = 5'($urandom_range(0, 16));
        tx_fifo_level = 5'($urandom_range(0, 2));
        rx_buf_full   = $urandom_range(0, 1);
        tx_buf_full   = ($urandom_range(0, 2) == 0);
        tx_shift_idle = $urandom_range(0, 1);
        rx_done       = ($urandom_range(0, 5) == 0);
        par_bad       = ($urandom_range(0, 7) == 0);
        stop_valid    = ($urandom_range(0, 5) == 0);
        stop_bit      = $urandom_range(0, 1);
        xfer_clk      = ($urandom_range(0, 3) == 0);
        rd_en         = ($urandom_range(0, 4) == 0);
        tick("R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 random");
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule